// File: doc/BRIEF.md
# Flash Synchronous Burst Read Sequencer

This block is the device-side read sequencer of a NOR-style flash. It takes the chip-enable and address-valid strobes, the start address and a small read configuration, and decides which word leaves on the 16-bit data output and when. Out of reset the device reads in asynchronous mode: the word at the presented address is passed straight through, and no clock edge is needed. Once the configuration enables synchronous operation, each access latches a start address, holds a wait indication through a programmable latency, and then delivers one word per rising clock edge.

A two-bit read-state register picks the data source. In the array state, words come from the memory array through the `mem_addr`/`mem_rdata` pair, and the address steps once per edge, wrapping inside an aligned window for the fixed burst lengths. In the three non-array states (identifier, status, query) a neighbouring block supplies one word on `nonarray_rdata`, and the sequencer repeats that word on every edge until the burst length is met. Command decoding is reduced to a write strobe carrying the new read state.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset, synchronous mode is off, latency code is 7, burst code is 3 (continuous), the read state is Array (code 0), `wait_o` is low and `dq_valid` follows only `ce_n`.
- R2: With `sync_en` clear, `mem_addr` equals `addr_in`, `dq` shows `mem_rdata` in the Array state or `nonarray_rdata` otherwise, `dq_valid` is the inverse of `ce_n`, and `wait_o` stays low, all without a clock edge.
- R3: The read state (0 Array, 1 Identifier, 2 Status, 3 Query) is loaded from `cmd_state` only on a clock edge with `cmd_wr` high, and otherwise keeps its value; it is visible on `read_state`.
- R4: On a clock edge with `cfg_wr` high, the sequencer takes `cfg_sync`, `cfg_lat` and `cfg_blen` as its new configuration.
- R5: In synchronous mode, the start address is latched on the first rising edge at which the sequencer is idle and both `ce_n` and `adv_n` are low; later changes of `adv_n` or `addr_in` have no effect until `ce_n` goes high.
- R6: From the latch edge until the first word, `wait_o` is high and `dq_valid` low; the first word is valid after the edge that lies L edges after the latch edge, where L is `cfg_lat`, and codes 0 and 1 count as 2. `wait_o` and `dq_valid` are never high together.
- R7: In an Array burst of fixed length N (burst code 0: 4 words, 1: 8, 2: 16), word i comes from the start address with its low log2(N) bits replaced by (start + i) mod N.
- R8: With burst code 3 (continuous), word i of an Array burst comes from start + i modulo the address range, and the burst does not end while `ce_n` stays low.
- R9: After N words of a fixed-length burst, `dq_valid` falls and stays low until `ce_n` returns high and a new address is latched.
- R10: In a synchronous non-array burst, the word sampled from `nonarray_rdata` on the first data edge is driven on every following edge, for N words or without end for burst code 3.
- R11: Raising `ce_n` drops `dq_valid` and `wait_o` at once, returns the sequencer to idle at the next edge, and a following access starts a new burst correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address valid |
| addr_in | input | AW | Start address from the host |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_sync | input | 1 | Synchronous mode enable |
| cfg_lat | input | 3 | Latency code |
| cfg_blen | input | 2 | Burst length code |
| cmd_wr | input | 1 | Read-state load strobe |
| cmd_state | input | 2 | New read-state code |
| mem_rdata | input | DW | Array word at `mem_addr` |
| nonarray_rdata | input | DW | Word for the current non-array state |
| mem_addr | output | AW | Array address being read |
| dq | output | DW | Output data word |
| dq_valid | output | 1 | Data word on `dq` is valid |
| wait_o | output | 1 | Data not yet valid during latency |
| read_state | output | 2 | Current read-state code |

## Verification
Asynchronous reads at random addresses in both read states show that data passes through combinationally and that no wait is raised. Synchronous bursts are run with random start addresses, all eight latency codes and all four burst codes, so that the position of the first word, the window wrap against a linear run, and the end of a fixed burst are all measured against each other. Non-array bursts with a random supplied word separate repetition from address stepping. Bursts that hold `adv_n` low against bursts that release it and scramble `addr_in`, a mid-burst chip-enable abort, and a read-state input changed without its strobe show that the latched state is immune to later input changes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_IDENT  = 2'd1,
    RS_STATUS = 2'd2,
    RS_QUERY  = 2'd3
  } rd_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAT,
    SQ_DATA,
    SQ_DONE
  } seq_state_e;

  typedef struct packed {
    logic       sync_en;
    logic [2:0] lat;
    logic [1:0] blen;
  } rcfg_t;

  localparam rcfg_t RCFG_RESET = '{sync_en: 1'b0, lat: 3'd7, blen: 2'd3};
  localparam logic [1:0] BLEN_CONT = 2'd3;

  // Latency codes below two are raised to two.
  function automatic logic [2:0] eff_latency(input logic [2:0] lat);
    return (lat < 3'd2) ? 3'd2 : lat;
  endfunction

  // Word count of a fixed burst; zero stands for continuous.
  function automatic logic [4:0] burst_words(input logic [1:0] blen);
    case (blen)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      2'd2:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fseq_cfg_regs.sv
module fseq_cfg_regs
  import fseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  rcfg_t     cfg_in,
  input  logic      cmd_wr,
  input  rd_state_e cmd_state,
  output rcfg_t     cfg_q,
  output rd_state_e rs_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= RCFG_RESET;
      rs_q  <= RS_ARRAY;
    end else begin
      if (cfg_wr) cfg_q <= cfg_in;
      if (cmd_wr) rs_q  <= cmd_state;
    end
  end

  // R3
  rstate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(rs_q));

endmodule

// File: rtl/fseq_addr_gen.sv
module fseq_addr_gen
  import fseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_evt,
  input  logic          sync_en,
  input  logic [1:0]    blen,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] nbeat,
  output logic [AW-1:0] mem_addr
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] win_mask;

  function automatic logic [AW-1:0] wrap_addr(input logic [AW-1:0] base,
                                               input logic [AW-1:0] off,
                                               input logic [AW-1:0] mask,
                                               input logic          cont);
    logic [AW-1:0] lin;
    lin = base + off;
    return cont ? lin : ((base & ~mask) | (lin & mask));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         base_q <= '0;
    else if (latch_evt) base_q <= addr_in;
  end

  assign win_mask = AW'(burst_words(blen)) - AW'(1);
  assign mem_addr = sync_en ? wrap_addr(base_q, nbeat, win_mask, blen == BLEN_CONT)
                            : addr_in;

  // R7
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && blen != BLEN_CONT) |-> ((mem_addr & ~win_mask) == (base_q & ~win_mask)));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  rcfg_t         cfg,
  output seq_state_e    st,
  output logic [AW-1:0] nbeat,
  output logic          latch_evt,
  output logic          first_evt,
  output logic          load_evt
);

  logic [2:0] lat_cnt;
  logic [4:0] blen_w;
  logic       cont;
  logic       last_reached;

  assign blen_w       = burst_words(cfg.blen);
  assign cont         = (cfg.blen == BLEN_CONT);
  assign latch_evt    = cfg.sync_en && st == SQ_IDLE && !ce_n && !adv_n;
  assign first_evt    = st == SQ_LAT && lat_cnt == 3'd1 && !ce_n;
  assign last_reached = st == SQ_DATA && !cont && nbeat == AW'(blen_w);
  assign load_evt     = first_evt || (st == SQ_DATA && !ce_n && !last_reached);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      nbeat   <= '0;
      lat_cnt <= 3'd2;
    end else if (ce_n) begin
      st    <= SQ_IDLE;
      nbeat <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (latch_evt) begin
          st      <= SQ_LAT;
          lat_cnt <= eff_latency(cfg.lat);
          nbeat   <= '0;
        end
        SQ_LAT: if (lat_cnt == 3'd1) begin
          st    <= SQ_DATA;
          nbeat <= AW'(1);
        end else begin
          lat_cnt <= lat_cnt - 3'd1;
        end
        SQ_DATA: if (last_reached) st <= SQ_DONE;
                 else              nbeat <= nbeat + AW'(1);
        default: ;
      endcase
    end
  end

  // Edge count since the latch edge, used only by the latency check.
  logic [3:0] since_latch;
  always_ff @(posedge clk) begin
    if (!rst_n)                               since_latch <= '0;
    else if (latch_evt)                       since_latch <= 4'd1;
    else if (st == SQ_LAT && since_latch < 4'd15) since_latch <= since_latch + 4'd1;
  end

  // R6
  lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_evt |-> (since_latch == {1'b0, eff_latency(cfg.lat)}));

  // R9
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_DATA && !cont) |-> (nbeat <= AW'(blen_w)));

  // R11
  ce_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (st == SQ_IDLE));

endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import fseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cfg_wr,
  input  logic          cfg_sync,
  input  logic [2:0]    cfg_lat,
  input  logic [1:0]    cfg_blen,
  input  logic          cmd_wr,
  input  logic [1:0]    cmd_state,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] nonarray_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq,
  output logic          dq_valid,
  output logic          wait_o,
  output logic [1:0]    read_state
);

  rcfg_t         cfg_in, cfg_q;
  rd_state_e     rs_q;
  seq_state_e    st;
  logic [AW-1:0] nbeat;
  logic          latch_evt, first_evt, load_evt;
  logic [DW-1:0] dq_q;
  logic          vld_q;
  logic [DW-1:0] src_word;

  assign cfg_in = '{sync_en: cfg_sync, lat: cfg_lat, blen: cfg_blen};

  fseq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_in(cfg_in),
    .cmd_wr(cmd_wr), .cmd_state(rd_state_e'(cmd_state)),
    .cfg_q(cfg_q), .rs_q(rs_q)
  );

  fseq_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .cfg(cfg_q),
    .st(st), .nbeat(nbeat), .latch_evt(latch_evt),
    .first_evt(first_evt), .load_evt(load_evt)
  );

  fseq_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .sync_en(cfg_q.sync_en),
    .blen(cfg_q.blen), .addr_in(addr_in), .nbeat(nbeat), .mem_addr(mem_addr)
  );

  assign src_word = (rs_q == RS_ARRAY) ? mem_rdata : nonarray_rdata;

  // Registered synchronous data path; non-array words are held after the first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_q  <= '0;
      vld_q <= 1'b0;
    end else if (ce_n || !load_evt) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (rs_q == RS_ARRAY || first_evt) dq_q <= src_word;
    end
  end

  always_comb begin
    if (cfg_q.sync_en) begin
      dq       = dq_q;
      dq_valid = vld_q && !ce_n;
      wait_o   = (st == SQ_LAT) && !ce_n;
    end else begin
      dq       = src_word;
      dq_valid = !ce_n;
      wait_o   = 1'b0;
    end
  end

  assign read_state = rs_q;

  // R6
  wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_o && dq_valid));

  // R2
  async_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.sync_en |-> !wait_o);

  // R10
  nonarray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(vld_q) && rs_q != RS_ARRAY && $stable(rs_q)) |-> $stable(dq_q));

endmodule

// File: tb/test_flash_burst_seq.sv
module test_flash_burst_seq;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cfg_wr = 1'b0, cfg_sync = 1'b0;
  logic [2:0]    cfg_lat = 3'd0;
  logic [1:0]    cfg_blen = 2'd0;
  logic          cmd_wr = 1'b0;
  logic [1:0]    cmd_state = 2'd0;
  logic [DW-1:0] mem_rdata, nonarray_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq;
  logic          dq_valid, wait_o;
  logic [1:0]    read_state;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Bench memory model: byte swap mixed with a constant.
  function automatic logic [DW-1:0] mword(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  assign mem_rdata = mword(mem_addr);

  flash_burst_seq #(.AW(AW), .DW(DW)) i_flash_burst_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in),
    .cfg_wr(cfg_wr), .cfg_sync(cfg_sync), .cfg_lat(cfg_lat), .cfg_blen(cfg_blen),
    .cmd_wr(cmd_wr), .cmd_state(cmd_state), .mem_rdata(mem_rdata),
    .nonarray_rdata(nonarray_rdata), .mem_addr(mem_addr), .dq(dq),
    .dq_valid(dq_valid), .wait_o(wait_o), .read_state(read_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic int eff_lat(input int lc);
    return (lc < 2) ? 2 : lc;
  endfunction

  // Expected array address of word i: offset inside a window of L words.
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int i,
                                             input int blen);
    int L, off;
    if (blen == 3) return base + AW'(i);
    L   = 4 << blen;
    off = int'(base) % L;
    return base - AW'(off) + AW'((off + i) % L);
  endfunction

  task automatic set_cfg(input bit s, input int lc, input int bl);
    @(negedge clk);
    cfg_wr = 1; cfg_sync = s; cfg_lat = 3'(lc); cfg_blen = 2'(bl);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic set_state(input int rs);
    @(negedge clk);
    cmd_wr = 1; cmd_state = 2'(rs);
    @(negedge clk);
    cmd_wr = 0;
  endtask

  // Runs one synchronous burst; abort_at >= 0 raises ce_n after that many words.
  task automatic run_burst(input logic [AW-1:0] base, input int lc, input int bl,
                           input int rs, input bit adv_hold, input int abort_at);
    int n;
    int el;
    logic [DW-1:0] na;
    el = eff_lat(lc);
    n  = (bl == 3) ? 20 : (4 << bl);
    na = 16'($urandom);
    nonarray_rdata = na;
    @(negedge clk);
    ce_n = 0; adv_n = 0; addr_in = base;
    @(negedge clk);  // latch edge has passed
    if (!adv_hold) begin
      adv_n = 1; addr_in = 16'($urandom);  // R5: ignored once latched
    end
    chk("R6 wait after latch", {30'd0, wait_o, dq_valid}, 32'd2);
    for (int k = 1; k < el; k++) begin
      @(negedge clk);
      chk("R6 latency wait", {30'd0, wait_o, dq_valid}, 32'd2);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (abort_at >= 0 && i == abort_at) begin
        ce_n = 1; adv_n = 1;
        #1;
        chk("R11 abort valid/wait", {30'd0, wait_o, dq_valid}, 32'd0);
        @(negedge clk);
        return;
      end
      chk("R6 first/next word valid", {30'd0, wait_o, dq_valid}, 32'd1);
      if (rs == 0)
        chk(bl == 3 ? "R8 continuous word" : "R7 wrapped word", dq,
            mword(exp_addr(base, i, bl)));
      else
        chk("R10 non-array repeat", dq, na);
      if (i == 0) nonarray_rdata = ~na;  // later changes must not show
    end
    if (bl != 3) begin
      adv_n = 0;
      @(negedge clk);
      chk("R9 end of burst", {30'd0, wait_o, dq_valid}, 32'd0);
      @(negedge clk);
      chk("R9 stays ended", {30'd0, wait_o, dq_valid}, 32'd0);
    end
    ce_n = 1; adv_n = 1;
    #1;
    chk("R11 ce_n high", {30'd0, wait_o, dq_valid}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 read_state", {30'd0, read_state}, 32'd0);
    chk("R1 wait/valid idle", {30'd0, wait_o, dq_valid}, 32'd0);

    // R2 asynchronous reads after reset, both sources
    for (int j = 0; j < 6; j++) begin
      logic [AW-1:0] a;
      a = 16'($urandom);
      ce_n = 0; addr_in = a;
      #2;
      chk("R1 R2 async wait/valid", {30'd0, wait_o, dq_valid}, 32'd1);
      chk("R2 async addr", mem_addr, a);
      chk("R2 async data", dq, mword(a));
      @(negedge clk);
    end
    ce_n = 1;
    #1;
    chk("R2 async ce high", {31'd0, dq_valid}, 32'd0);

    // R3 state not loaded without strobe
    @(negedge clk);
    cmd_state = 2'd2;
    @(negedge clk);
    chk("R3 no strobe", {30'd0, read_state}, 32'd0);
    set_state(2);
    chk("R3 status loaded", {30'd0, read_state}, 32'd2);
    nonarray_rdata = 16'hBEEF; ce_n = 0; addr_in = 16'h0042;
    #2;
    chk("R2 async non-array", dq, 16'hBEEF);
    @(negedge clk);
    ce_n = 1;
    set_state(0);

    // Directed corners: R4 config, wrap near window end, low latency codes
    set_cfg(1, 0, 0);
    run_burst(16'h0006, 0, 0, 0, 1'b1, -1);
    set_cfg(1, 1, 2);
    run_burst(16'h001D, 1, 2, 0, 1'b0, -1);
    set_cfg(1, 7, 3);
    run_burst(16'hFFFC, 7, 3, 0, 1'b0, -1);
    set_cfg(1, 3, 1);
    run_burst(16'h0105, 3, 1, 0, 1'b0, 3);  // R11 abort
    run_burst(16'h0203, 3, 1, 0, 1'b1, -1); // restart after abort
    set_state(3);
    run_burst(16'h0300, 3, 1, 3, 1'b0, -1);
    set_cfg(1, 2, 3);
    run_burst(16'h0011, 2, 3, 3, 1'b1, -1);

    // Constrained random bursts
    for (int r = 0; r < 40; r++) begin
      int lc, bl, rs;
      lc = int'($urandom_range(7, 0));
      bl = int'($urandom_range(3, 0));
      rs = ($urandom_range(2, 0) == 0) ? int'($urandom_range(3, 1)) : 0;
      set_state(rs);
      set_cfg(1, lc, bl);
      run_burst(16'($urandom), lc, bl, rs, 1'($urandom), -1);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule